// File: doc/BRIEF.md
# Runlist Timeslice Channel Scheduler

This block shares a single execution engine among up to sixteen work channels. It walks a programmable list of channel identifiers, the runlist, one entry at a time. At each entry it looks at that channel's work-pending flag. An entry whose channel has nothing to do is passed over in a single clock. An entry whose channel has work is granted the engine, and the grant lasts until the engine signals that the work is done or until the channel's own timeslice runs out.

Each channel carries a timeslice length and a flag that says whether the channel may be preempted. A channel can be given a larger share of the engine by listing it in several runlist entries. Software loads the runlist entries, the active list length and the per-channel settings through simple write strobes. The engine is told which channel it owns, when the grant is valid, and when it must yield because a timeslice has expired.

Top module: `runlist_sched`

## Requirements
- R1: After reset, grantValid, preemptReq and grantChan are all 0, the active runlist length is 0, and no grant is issued even when every channel has pending work.
- R2: Entries are visited in ascending index order over the first L entries, where L is the programmed length (values above the depth are clamped to the depth). After entry L-1 the walk wraps to entry 0. A length of 0 stops the walk.
- R3: Visiting an entry whose channel has no pending work takes exactly one clock cycle, and grantValid stays low during that cycle.
- R4: When the visited entry's channel has pending work, grantValid rises on the next clock edge and grantChan shows that channel's ID.
- R5: A grant ends on the clock edge where workDone is sampled high. grantValid is low in the following cycle, and the walk moves on to the next entry.
- R6: For a preemptible channel with timeslice S, a grant lasts at most S cycles. preemptReq is high during the last of those cycles, and the grant ends after it. A programmed timeslice of 0 behaves as 1.
- R7: A non-preemptible channel keeps its grant after its timeslice has run out, until workDone is sampled high. preemptReq is never raised for such a channel.
- R8: A channel listed in k entries receives k grants in each pass of the runlist, in list order.
- R9: Rewriting a runlist entry while a grant is active leaves grantChan unchanged. The new content is used the next time that entry is visited.
- R10: While no channel in the active runlist has pending work, grantValid stays low.
- R11: grantChan stays stable for as long as grantValid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rstN | input | 1 | Asynchronous reset, active low |
| workPending | input | 16 | Per-channel flag, high when the channel has queued work |
| workDone | input | 1 | Engine reports that the granted channel's work is finished |
| rlWe | input | 1 | Write strobe for one runlist entry |
| rlIdx | input | 4 | Index of the runlist entry to write |
| rlChan | input | 4 | Channel ID to store in that entry |
| lenWe | input | 1 | Write strobe for the active runlist length |
| lenVal | input | 5 | New active length (0 to 16) |
| chWe | input | 1 | Write strobe for one channel's settings |
| chSel | input | 4 | Channel whose settings are written |
| chSlice | input | 8 | Timeslice length in clock cycles |
| chPreempt | input | 1 | 1 = channel may be preempted when its timeslice expires |
| grantChan | output | 4 | ID of the channel that owns the engine |
| grantValid | output | 1 | High while a channel owns the engine |
| preemptReq | output | 1 | High in the last cycle of an expiring preemptible timeslice |

## Verification
The bench builds the block with its defaults: sixteen channels, sixteen runlist entries and 8-bit timeslices. This allows channel IDs up to 15, a full 16-entry list, and a 200-cycle timeslice to be tested alongside timeslices of 0 and 1. A four-entry list with two idle channels exposes the one-cycle skip cost and the wrap-around timing, measured as exact cycle gaps between grants. A three-entry list that names one channel twice shows the weighted order.

// File: rtl/rlsched_pkg.sv
package rlsched_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic take;    // latch the visited entry as the new grant
    logic step;    // advance the runlist pointer with wrap
    logic rewind;  // force the pointer back to entry 0
    logic tick;    // count one cycle of the running timeslice
  } ctrlStrobeT;

  // Status from the datapath back to the control FSM
  typedef struct packed {
    logic entryHasWork;
    logic ptrValid;
    logic sliceLast;
    logic curPreempt;
  } dpStatusT;

  typedef enum logic {
    ST_SCAN = 1'b0,
    ST_RUN  = 1'b1
  } schedStateT;

endpackage

// File: rtl/rlsched_datapath.sv
module rlsched_datapath
  import rlsched_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int RL_DEPTH = 16,
  parameter int TS_W     = 8,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int IDX_W   = $clog2(RL_DEPTH),
  localparam int LEN_W   = $clog2(RL_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] workPending,
  input  logic              rlWe,
  input  logic [IDX_W-1:0]  rlIdx,
  input  logic [CH_W-1:0]   rlChan,
  input  logic              lenWe,
  input  logic [LEN_W-1:0]  lenVal,
  input  logic              chWe,
  input  logic [CH_W-1:0]   chSel,
  input  logic [TS_W-1:0]   chSlice,
  input  logic              chPreempt,
  input  ctrlStrobeT        stb,
  output dpStatusT          st,
  output logic [CH_W-1:0]   grantChan
);

  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(RL_DEPTH);

  logic [CH_W-1:0]   runlist  [RL_DEPTH];
  logic [TS_W-1:0]   sliceCfg [NUM_CH];
  logic [NUM_CH-1:0] preemptCfg;
  logic [LEN_W-1:0]  rlLen;
  logic [IDX_W-1:0]  ptr;
  logic [IDX_W-1:0]  nextPtr;
  logic [LEN_W-1:0]  ptrInc;
  logic [TS_W-1:0]   sliceCnt;
  logic [TS_W-1:0]   sliceLoad;
  logic              curPre;
  logic [CH_W-1:0]   entryChan;

  // Runlist storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < RL_DEPTH; e++) runlist[e] <= '0;
    end else if (rlWe && (int'(rlIdx) < RL_DEPTH)) begin
      runlist[rlIdx] <= rlChan;
    end
  end

  // Per-channel settings, one register group per channel
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) preemptCfg[c] <= 1'b1;
      else if (chWe && chSel == CH_W'(c)) preemptCfg[c] <= chPreempt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) sliceCfg[c] <= TS_W'(1);
    end else if (chWe) begin
      sliceCfg[chSel] <= chSlice;
    end
  end

  // Active length, clamped to the depth
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rlLen <= '0;
    else if (lenWe) rlLen <= (lenVal > MAX_LEN) ? MAX_LEN : lenVal;
  end

  // Entry lookup and pointer walk
  assign entryChan = runlist[ptr];
  assign ptrInc    = LEN_W'(ptr) + 1'b1;
  assign nextPtr   = (ptrInc >= rlLen) ? '0 : IDX_W'(ptrInc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           ptr <= '0;
    else if (stb.rewind) ptr <= '0;
    else if (stb.step)   ptr <= nextPtr;
  end

  // Grant latch and timeslice counter
  assign sliceLoad = (sliceCfg[entryChan] == '0) ? TS_W'(1) : sliceCfg[entryChan];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantChan <= '0;
      sliceCnt  <= '0;
      curPre    <= 1'b0;
    end else if (stb.take) begin
      grantChan <= entryChan;
      sliceCnt  <= sliceLoad;
      curPre    <= preemptCfg[entryChan];
    end else if (stb.tick && sliceCnt != '0) begin
      sliceCnt <= sliceCnt - 1'b1;
    end
  end

  always_comb begin
    st.entryHasWork = workPending[entryChan];
    st.ptrValid     = (LEN_W'(ptr) < rlLen);
    st.sliceLast    = (sliceCnt == TS_W'(1));
    st.curPreempt   = curPre;
  end

  // R2
  ptr_walk_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.step |=> (ptr == '0 || ptr == IDX_W'($past(ptr) + 1'b1)));

  // R9
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.take |=> $stable(grantChan));

endmodule

// File: rtl/rlsched_control.sv
module rlsched_control
  import rlsched_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       workDone,
  input  dpStatusT   st,
  output ctrlStrobeT stb,
  output logic       grantValid,
  output logic       preemptReq
);

  schedStateT state;
  logic       releaseNow;

  always_comb begin
    stb        = '0;
    releaseNow = 1'b0;
    if (state == ST_SCAN) begin
      if (!st.ptrValid)         stb.rewind = 1'b1;
      else if (st.entryHasWork) stb.take   = 1'b1;
      else                      stb.step   = 1'b1;
    end else begin
      releaseNow = workDone || (st.sliceLast && st.curPreempt);
      stb.step   = releaseNow;
      stb.tick   = !releaseNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               state <= ST_SCAN;
    else if (state == ST_SCAN && stb.take)   state <= ST_RUN;
    else if (state == ST_RUN  && releaseNow) state <= ST_SCAN;
  end

  assign grantValid = (state == ST_RUN);
  assign preemptReq = (state == ST_RUN) && st.sliceLast && st.curPreempt;

  // R5
  done_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid && workDone |=> !grantValid);

  // R6
  preempt_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    preemptReq |=> !grantValid);

  // R7
  hold_nonpreempt_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid && !st.curPreempt && !workDone |=> grantValid);

  // R4
  take_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.take |=> grantValid);

endmodule

// File: rtl/runlist_sched.sv
module runlist_sched
  import rlsched_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int RL_DEPTH = 16,
  parameter int TS_W     = 8,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int IDX_W   = $clog2(RL_DEPTH),
  localparam int LEN_W   = $clog2(RL_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] workPending,
  input  logic              workDone,
  input  logic              rlWe,
  input  logic [IDX_W-1:0]  rlIdx,
  input  logic [CH_W-1:0]   rlChan,
  input  logic              lenWe,
  input  logic [LEN_W-1:0]  lenVal,
  input  logic              chWe,
  input  logic [CH_W-1:0]   chSel,
  input  logic [TS_W-1:0]   chSlice,
  input  logic              chPreempt,
  output logic [CH_W-1:0]   grantChan,
  output logic              grantValid,
  output logic              preemptReq
);

  ctrlStrobeT stb;
  dpStatusT   st;

  rlsched_datapath #(
    .NUM_CH(NUM_CH), .RL_DEPTH(RL_DEPTH), .TS_W(TS_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .workPending(workPending),
    .rlWe(rlWe), .rlIdx(rlIdx), .rlChan(rlChan),
    .lenWe(lenWe), .lenVal(lenVal),
    .chWe(chWe), .chSel(chSel), .chSlice(chSlice), .chPreempt(chPreempt),
    .stb(stb), .st(st), .grantChan(grantChan)
  );

  rlsched_control u_ctl (
    .clk(clk), .rstN(rstN), .workDone(workDone), .st(st),
    .stb(stb), .grantValid(grantValid), .preemptReq(preemptReq)
  );

  // R11
  grant_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid && $past(grantValid) |-> $stable(grantChan));

endmodule

// File: tb/runlist_sched_bench.sv
module runlist_sched_bench;

  localparam int NUM_CH = 16;
  localparam int NV     = 8;

  typedef struct packed {
    int ch; int slice; int pre; int doneAfter; int expCycles; int expPre;
  } vecT;

  // channel, timeslice, preemptible, done after n grant cycles (0 = never), expected length, expected preempt pulses
  localparam vecT VECS [NV] = '{
    '{3,   4, 1, 0,   4, 1},
    '{5,   4, 1, 2,   2, 0},
    '{7,   0, 1, 0,   1, 1},
    '{2,   3, 0, 6,   6, 0},
    '{9,   5, 1, 5,   5, 1},
    '{15,  1, 0, 1,   1, 0},
    '{0, 200, 1, 0, 200, 1},
    '{11,  2, 0, 9,   9, 0}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NUM_CH-1:0] workPending = '0;
  logic              workDone = 1'b0;
  logic              rlWe = 1'b0;
  logic [3:0]        rlIdx = '0;
  logic [3:0]        rlChan = '0;
  logic              lenWe = 1'b0;
  logic [4:0]        lenVal = '0;
  logic              chWe = 1'b0;
  logic [3:0]        chSel = '0;
  logic [7:0]        chSlice = '0;
  logic              chPreempt = 1'b0;
  logic [3:0]        grantChan;
  logic              grantValid;
  logic              preemptReq;

  int nChecks = 0;
  int nErrors = 0;

  always #5 clk = ~clk;

  runlist_sched u_runlist_sched (
    .clk(clk), .rstN(rstN), .workPending(workPending), .workDone(workDone),
    .rlWe(rlWe), .rlIdx(rlIdx), .rlChan(rlChan), .lenWe(lenWe), .lenVal(lenVal),
    .chWe(chWe), .chSel(chSel), .chSlice(chSlice), .chPreempt(chPreempt),
    .grantChan(grantChan), .grantValid(grantValid), .preemptReq(preemptReq)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrRl(input int idx, input int ch);
    rlWe = 1'b1; rlIdx = 4'(idx); rlChan = 4'(ch);
    @(negedge clk); rlWe = 1'b0;
  endtask

  task automatic wrLen(input int len);
    lenWe = 1'b1; lenVal = 5'(len);
    @(negedge clk); lenWe = 1'b0;
  endtask

  task automatic wrCh(input int ch, input int slice, input int pre);
    chWe = 1'b1; chSel = 4'(ch); chSlice = 8'(slice); chPreempt = pre[0];
    @(negedge clk); chWe = 1'b0;
  endtask

  task automatic goIdle();
    workPending = '0; workDone = 1'b0;
    repeat (3) @(negedge clk);
    wrLen(0);
    repeat (2) @(negedge clk);
  endtask

  // Waits for the next rising edge of grantValid; gap counts negedges waited
  task automatic nextRise(output int ch, output int gap);
    logic prev;
    prev = grantValid; gap = 0; ch = -1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      gap++;
      if (grantValid && !prev) begin
        ch = int'(grantChan);
        break;
      end
      prev = grantValid;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErrors++; nChecks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    int ch, gap, cnt, seen, cycles, pcnt, chanBad, firstChan, guard;
    int order [6];
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state, and no grant with an empty list even with all work pending
    check("R1 grantValid", int'(grantValid), 0);
    check("R1 preemptReq", int'(preemptReq), 0);
    check("R1 grantChan", int'(grantChan), 0);
    workPending = '1;
    cnt = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); cnt += int'(grantValid); end
    check("R1 no grant at length 0", cnt, 0);
    workPending = '0;

    // Table-driven single-channel grants: R4, R5, R6, R7, R11
    for (int v = 0; v < NV; v++) begin
      wrLen(0);
      wrCh(VECS[v].ch, VECS[v].slice, VECS[v].pre);
      wrRl(0, VECS[v].ch);
      wrLen(1);
      workPending = '0; workPending[VECS[v].ch] = 1'b1;
      seen = 0; cycles = 0; pcnt = 0; chanBad = 0; firstChan = -1; guard = 0;
      while (guard < 400) begin
        @(negedge clk); guard++;
        if (grantValid) begin
          if (!seen) firstChan = int'(grantChan);
          seen = 1; cycles++;
          if (int'(grantChan) != VECS[v].ch) chanBad++;
          if (preemptReq) pcnt++;
          workDone = (VECS[v].doneAfter != 0 && cycles == VECS[v].doneAfter);
        end else if (seen) begin
          workDone = 1'b0; workPending = '0;
          break;
        end
      end
      check("R4 granted channel", firstChan, VECS[v].ch);
      check(VECS[v].pre != 0 ? "R6 grant length" : "R7 grant length", cycles, VECS[v].expCycles);
      check(VECS[v].doneAfter != 0 ? "R5 preempt count" : "R6 preempt count", pcnt, VECS[v].expPre);
      check("R11 channel stable", chanBad, 0);
      goIdle();
    end

    // R2 and R3: list [1,2,3,4], only 1 and 4 pending, slices of 1
    wrCh(1, 1, 1); wrCh(4, 1, 1);
    wrRl(0, 1); wrRl(1, 2); wrRl(2, 3); wrRl(3, 4);
    workPending = '0; workPending[1] = 1'b1; workPending[4] = 1'b1;
    wrLen(4);
    nextRise(ch, gap); check("R2 first channel", ch, 1); check("R4 first gap", gap, 1);
    nextRise(ch, gap); check("R3 channel after skips", ch, 4); check("R3 gap over two skips", gap, 4);
    nextRise(ch, gap); check("R2 wrap channel", ch, 1); check("R2 wrap gap", gap, 2);
    nextRise(ch, gap); check("R3 second pass channel", ch, 4); check("R3 second pass gap", gap, 4);
    goIdle();

    // R8: list [6,6,8]
    wrCh(6, 1, 1); wrCh(8, 1, 1);
    wrRl(0, 6); wrRl(1, 6); wrRl(2, 8);
    workPending = '0; workPending[6] = 1'b1; workPending[8] = 1'b1;
    wrLen(3);
    for (int i = 0; i < 6; i++) begin nextRise(ch, gap); order[i] = ch; end
    check("R8 order 0", order[0], 6); check("R8 order 1", order[1], 6);
    check("R8 order 2", order[2], 8); check("R8 order 3", order[3], 6);
    check("R8 order 4", order[4], 6); check("R8 order 5", order[5], 8);
    goIdle();

    // R10: list present, nothing pending
    wrLen(3);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); cnt += int'(grantValid); end
    check("R10 no grant without work", cnt, 0);
    goIdle();

    // R7 and R9: non-preemptible channel 10, entry rewritten during its grant
    wrCh(10, 2, 0); wrCh(12, 1, 1);
    wrRl(0, 10);
    workPending = '0; workPending[10] = 1'b1;
    wrLen(1);
    nextRise(ch, gap); check("R4 channel 10", ch, 10);
    cnt = 0; pcnt = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (!grantValid) cnt++;
      if (preemptReq) pcnt++;
    end
    check("R7 held past timeslice", cnt, 0);
    check("R7 no preempt request", pcnt, 0);
    wrRl(0, 12);
    check("R9 channel kept after rewrite", int'(grantChan), 10);
    check("R9 grant kept after rewrite", int'(grantValid), 1);
    workPending = '0; workPending[12] = 1'b1;
    workDone = 1'b1;
    @(negedge clk);
    workDone = 1'b0;
    check("R5 released after done", int'(grantValid), 0);
    nextRise(ch, gap); check("R9 rewritten entry used", ch, 12);
    goIdle();

    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule